// File: doc/BRIEF.md
# Integer Shift Unit with Flags

This block is the shift slice of an integer execute stage with byte, halfword and word operands. In one combinational pass it shifts an operand left, logically right or arithmetically right. Alongside the result it produces the carry, overflow, zero, sign and parity flags, plus a strobe that says whether the flag register should take them.

The decoder feeds it three things. The first is the 3-bit opcode extension field, which picks the shift kind. The second is a 2-bit size code. The third is an 8-bit raw count, taken from an immediate byte, the count register or a hard-wired 1. The unit keeps only the low five bits of the count. Overflow is defined only for single-bit shifts and is driven as 0 otherwise, so the outputs are fully deterministic.

The result is returned zero-extended to 32 bits. The flags are computed at the selected width.

Top module: `shu_top`

## Requirements
- R1: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Only the selected low bits of the operand take part, and result bits above the selected width are always 0.
- R2: The extension field selects the kind. Value 4 is a left shift, 5 is a logical right shift and 7 is an arithmetic right shift. The values 0, 1, 2, 3 and 6 shift nothing: the result is the width-masked operand, the flag strobe is 0 and every flag output is 0.
- R3: Only bits 4:0 of the raw count are used. Two raw counts with the same low five bits give identical outputs.
- R4: A left shift by k moves bits toward the top and enters zeros at bit 0. CF is the last bit pushed out of the top, which is original bit (width-k), or 0 when k exceeds the width.
- R5: A logical right shift by k enters zeros at the top. CF is original bit k-1, or 0 when k exceeds the width.
- R6: An arithmetic right shift by k copies the original sign bit into the vacated top bits, so the signed result equals floor(operand / 2^k). CF is original bit k-1, or the sign bit when k exceeds the width.
- R7: With an effective count of 1, OF has a rule for each kind. For a left shift it is the result's top bit XOR CF. For an arithmetic right shift it is 0. For a logical right shift it is the original operand's top bit.
- R8: With an effective count above 1, OF is driven as 0.
- R9: When the flag strobe is 1, the flags follow the result at the selected width. ZF is 1 exactly when the result is zero. SF is the result's top bit. PF is 1 when bits 7:0 of the result hold an even number of ones.
- R10: With a valid kind and a nonzero effective count, the flag strobe is 1. With an effective count of 0, the result is the width-masked operand, the strobe is 0 and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand; only the selected width is used |
| size_i | input | 2 | Width code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| ext_i | input | 3 | Opcode extension: 4 left, 5 logical right, 7 arithmetic right |
| cnt_raw_i | input | 8 | Raw shift count; low five bits are used |
| res_o | output | 32 | Shifted result, zero above the selected width |
| cf_o | output | 1 | Carry: last bit shifted out |
| of_o | output | 1 | Overflow, defined for single-bit shifts, else 0 |
| zf_o | output | 1 | Result is zero |
| sf_o | output | 1 | Top bit of the result |
| pf_o | output | 1 | Even parity of the result's low byte |
| flag_we_o | output | 1 | Flags are to be written |

## Verification
The byte width is swept exhaustively. Every operand value is tried with all eight extension values and all 32 effective counts. This separates the kinds from one another, places the carry at every boundary, and exposes the rule at count equal to width versus count above width. At halfword width, a fixed set of edge operands is driven while the discarded count bits are varied, so a shifter that uses bits 7:5 of the count shows up as a mismatch. At word width the same edge operands expose any wrong fill or carry position in the top shifter stages. Arithmetic results are also compared against a floored signed division, computed separately from the bit-serial model the bench uses for all other expected values.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int XLEN  = 32;
  localparam int CNT_W = 5;

  localparam logic [2:0] EXT_SHL = 3'd4;
  localparam logic [2:0] EXT_SHR = 3'd5;
  localparam logic [2:0] EXT_SAR = 3'd7;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_LEFT,
    KIND_LRIGHT,
    KIND_ARIGHT
  } shift_kind_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic zf;
    logic sf;
    logic pf;
  } flags_t;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    ext_i,
  input  logic [7:0]    cnt_raw_i,
  output shift_kind_e   kind_o,
  output logic [CW-1:0] cnt_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] topsel_o,
  output logic [DW-1:0] opnd_z_o,
  output logic [DW-1:0] opnd_s_o,
  output logic          sign_o,
  output logic          active_o
);
  logic [DW-1:0] mask;
  logic [DW-1:0] topsel;
  logic          sign;

  always_comb begin
    case (size_i)
      2'd0:    mask = DW'({8{1'b1}});
      2'd1:    mask = DW'({16{1'b1}});
      default: mask = {DW{1'b1}};
    endcase
  end

  assign topsel = mask ^ (mask >> 1);
  assign sign   = |(opnd_i & topsel);

  always_comb begin
    case (ext_i)
      EXT_SHL: kind_o = KIND_LEFT;
      EXT_SHR: kind_o = KIND_LRIGHT;
      EXT_SAR: kind_o = KIND_ARIGHT;
      default: kind_o = KIND_NONE;
    endcase
  end

  assign cnt_o    = cnt_raw_i[CW-1:0];
  assign mask_o   = mask;
  assign topsel_o = topsel;
  assign sign_o   = sign;
  assign opnd_z_o = opnd_i & mask;
  assign opnd_s_o = (opnd_i & mask) | (sign ? ~mask : '0);
  assign active_o = (kind_o != KIND_NONE) && (cnt_o != '0);
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel #(
  parameter int W    = 64,
  parameter int SW   = 5,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]  din,
  input  logic          fill,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];

  assign stg[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    if (LEFT) begin : g_left
      assign stg[i+1] = amt[i] ? {stg[i][W-1-STEP:0], {STEP{1'b0}}} : stg[i];
    end else begin : g_right
      assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][W-1:STEP]} : stg[i];
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/shu_flags.sv
module shu_flags
  import shu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int CW = CNT_W
) (
  input  shift_kind_e   kind_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          active_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] topsel_i,
  input  logic          orig_sign_i,
  input  logic          cf_i,
  output flags_t        flags_o,
  output logic          we_o
);
  logic res_top;
  logic single;
  logic of_raw;

  assign res_top = |(res_i & topsel_i);
  assign single  = (cnt_i == CW'(1));

  always_comb begin
    case (kind_i)
      KIND_LEFT:   of_raw = res_top ^ cf_i;
      KIND_LRIGHT: of_raw = orig_sign_i;
      default:     of_raw = 1'b0;
    endcase
  end

  always_comb begin
    flags_o = '0;
    if (active_i) begin
      flags_o.cf = cf_i;
      flags_o.of = single & of_raw;
      flags_o.zf = (res_i == '0);
      flags_o.sf = res_top;
      flags_o.pf = ~^res_i[7:0];
    end
  end

  assign we_o = active_i;
endmodule

// File: rtl/shu_top.sv
module shu_top
  import shu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    ext_i,
  input  logic [7:0]    cnt_raw_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          pf_o,
  output logic          flag_we_o
);
  localparam int WW = 2 * DW;

  shift_kind_e   kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mask, topsel, opnd_z, opnd_s;
  logic          sign, active;
  logic [WW-1:0] lv, rv;
  logic [DW-1:0] res_sh, res;
  logic          cf_sh;
  flags_t        flags;

  shu_decode #(.DW(DW), .CW(CW)) u_dec (
    .opnd_i    (opnd_i),
    .size_i    (size_i),
    .ext_i     (ext_i),
    .cnt_raw_i (cnt_raw_i),
    .kind_o    (kind),
    .cnt_o     (cnt),
    .mask_o    (mask),
    .topsel_o  (topsel),
    .opnd_z_o  (opnd_z),
    .opnd_s_o  (opnd_s),
    .sign_o    (sign),
    .active_o  (active)
  );

  shu_barrel #(.W(WW), .SW(CW), .LEFT(1'b1)) u_lsh (
    .din  ({{DW{1'b0}}, opnd_z}),
    .fill (1'b0),
    .amt  (cnt),
    .dout (lv)
  );

  shu_barrel #(.W(WW), .SW(CW), .LEFT(1'b0)) u_rsh (
    .din  ({(kind == KIND_ARIGHT) ? opnd_s : opnd_z, {DW{1'b0}}}),
    .fill ((kind == KIND_ARIGHT) & sign),
    .amt  (cnt),
    .dout (rv)
  );

  always_comb begin
    if (kind == KIND_LEFT) begin
      res_sh = lv[DW-1:0] & mask;
      cf_sh  = |(lv & ({{DW{1'b0}}, topsel} << 1));
    end else begin
      res_sh = rv[WW-1:DW] & mask;
      cf_sh  = rv[DW-1];
    end
  end

  assign res = active ? res_sh : opnd_z;

  shu_flags #(.DW(DW), .CW(CW)) u_flg (
    .kind_i      (kind),
    .cnt_i       (cnt),
    .active_i    (active),
    .res_i       (res),
    .topsel_i    (topsel),
    .orig_sign_i (sign),
    .cf_i        (cf_sh),
    .flags_o     (flags),
    .we_o        (flag_we_o)
  );

  assign res_o = res;
  assign cf_o  = flags.cf;
  assign of_o  = flags.of;
  assign zf_o  = flags.zf;
  assign sf_o  = flags.sf;
  assign pf_o  = flags.pf;
endmodule

// File: rtl/shu_top_chk.sv
module shu_top_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0] opnd_i,
  input logic [1:0]    size_i,
  input logic [2:0]    ext_i,
  input logic [7:0]    cnt_raw_i,
  input logic [DW-1:0] res_o,
  input logic          cf_o,
  input logic          of_o,
  input logic          zf_o,
  input logic          sf_o,
  input logic          pf_o,
  input logic          flag_we_o
);
  logic [DW-1:0] wmask;
  logic [DW-1:0] tbit;
  logic [4:0]    k;

  always_comb begin
    case (size_i)
      2'd0:    wmask = DW'(8'hFF);
      2'd1:    wmask = DW'(16'hFFFF);
      default: wmask = {DW{1'b1}};
    endcase
    tbit = wmask ^ (wmask >> 1);
    k    = cnt_raw_i[4:0];
  end

  always_comb begin
    // R1
    upper_zero_chk: assert ((res_o & ~wmask) == '0)
      else $error("result bits above width are set");
    // R2
    if (!(ext_i inside {3'd4, 3'd5, 3'd7}))
      bad_ext_quiet_chk: assert (!flag_we_o && res_o == (opnd_i & wmask))
        else $error("non-shift extension altered output");
    // R10
    if (!flag_we_o)
      idle_flags_chk: assert (res_o == (opnd_i & wmask) && !cf_o && !of_o && !zf_o && !sf_o && !pf_o)
        else $error("idle unit drove result or flags");
    // R8
    if (k > 5'd1)
      multi_of_chk: assert (!of_o)
        else $error("overflow set on multi-bit shift");
    // R7
    if (ext_i == 3'd7)
      sar_of_chk: assert (!of_o)
        else $error("overflow set on arithmetic right shift");
    // R5
    if (ext_i == 3'd5 && k != 5'd0)
      shr_top_chk: assert ((res_o & tbit) == '0)
        else $error("logical right shift left top bit set");
    // R6
    if (ext_i == 3'd7)
      sar_sign_chk: assert (((res_o & tbit) != '0) == ((opnd_i & tbit) != '0))
        else $error("arithmetic right shift changed sign");
    // R9
    if (flag_we_o)
      zero_flag_chk: assert (zf_o == (res_o == '0))
        else $error("zero flag disagrees with result");
  end
endmodule

bind shu_top shu_top_chk #(.DW(DW)) u_chk (
  .opnd_i    (opnd_i),
  .size_i    (size_i),
  .ext_i     (ext_i),
  .cnt_raw_i (cnt_raw_i),
  .res_o     (res_o),
  .cf_o      (cf_o),
  .of_o      (of_o),
  .zf_o      (zf_o),
  .sf_o      (sf_o),
  .pf_o      (pf_o),
  .flag_we_o (flag_we_o)
);

// File: tb/sim_shu_top.sv
module sim_shu_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] opnd;
  logic [1:0]  size;
  logic [2:0]  ext;
  logic [7:0]  cnt_raw;
  logic [31:0] res;
  logic        cf, of, zf, sf, pf, we;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  shu_top u0 (
    .opnd_i    (opnd),
    .size_i    (size),
    .ext_i     (ext),
    .cnt_raw_i (cnt_raw),
    .res_o     (res),
    .cf_o      (cf),
    .of_o      (of),
    .zf_o      (zf),
    .sf_o      (sf),
    .pf_o      (pf),
    .flag_we_o (we)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h (size=%0d ext=%0d cnt=%0d opnd=%h)",
               tag, what, got, exp, size, ext, cnt_raw, opnd);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h8000_0000;
      3:  return 32'h7FFF_FFFF;
      4:  return 32'hFFFF_FFFF;
      5:  return 32'hA5A5_5A5A;
      6:  return 32'h0000_8001;
      7:  return 32'h1234_5678;
      8:  return 32'hC000_0001;
      9:  return 32'h4000_0000;
      10: return 32'h0000_00FF;
      default: return 32'h8765_C321;
    endcase
  endfunction

  // Bit-serial reference, one position per loop pass.
  task automatic model(input logic [1:0] sz, input logic [2:0] e, input logic [31:0] x,
                       input logic [7:0] raw, output logic [31:0] r,
                       output logic ecf, output logic eof, output logic ezf,
                       output logic esf, output logic epf, output logic ewe);
    int w;
    logic [31:0] m, v;
    logic top, otop;
    int k;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    v = x & m;
    k = int'(raw[4:0]);
    otop = v[w-1];
    ecf = 0; eof = 0; ezf = 0; esf = 0; epf = 0; ewe = 0;
    if (!(e inside {3'd4, 3'd5, 3'd7}) || k == 0) begin
      r = v;
      return;
    end
    for (int i = 0; i < k; i++) begin
      if (e == 3'd4) begin
        ecf = v[w-1];
        v = (v << 1) & m;
      end else begin
        ecf = v[0];
        top = v[w-1];
        v = v >> 1;
        if (e == 3'd7 && top) v[w-1] = 1'b1;
      end
    end
    r = v;
    ewe = 1;
    if (k == 1) eof = (e == 3'd4) ? (v[w-1] ^ ecf) : (e == 3'd5) ? otop : 1'b0;
    ezf = (v == 0);
    esf = v[w-1];
    epf = ~^v[7:0];
  endtask

  task automatic run(input logic [1:0] sz, input logic [2:0] e, input logic [31:0] x,
                     input logic [7:0] raw, input string force_tag);
    logic [31:0] er;
    logic ecf, eof, ezf, esf, epf, ewe;
    string t;
    size = sz; ext = e; opnd = x; cnt_raw = raw;
    #2;
    model(sz, e, x, raw, er, ecf, eof, ezf, esf, epf, ewe);
    if (force_tag != "") t = force_tag;
    else if (!(e inside {3'd4, 3'd5, 3'd7})) t = "R2";
    else if (raw[4:0] == 5'd0) t = "R10";
    else if (e == 3'd4) t = "R4";
    else if (e == 3'd5) t = "R5";
    else t = "R6";
    chk(t, "result", res, er);
    chk(t, "cf", 32'(cf), 32'(ecf));
    chk((raw[4:0] == 5'd1) ? "R7" : "R8", "of", 32'(of), 32'(eof));
    chk("R9", "zf/sf/pf", {29'd0, zf, sf, pf}, {29'd0, ezf, esf, epf});
    chk("R10", "flag_we", 32'(we), 32'(ewe));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int q;
    int sx;
    opnd = '0; size = '0; ext = '0; cnt_raw = '0;
    #5;
    // Quiet state with all-zero inputs
    chk("R10", "initial result", res, 32'h0);
    chk("R10", "initial strobe", 32'(we), 32'h0);

    // Byte width, exhaustive; raw count upper bits vary with the operand
    for (int x = 0; x < 256; x++) begin
      for (int e = 0; e < 8; e++) begin
        for (int k = 0; k < 32; k++) begin
          run(2'd0, 3'(e), 32'(x) | 32'hABCD_0000, 8'(k + 32 * (x % 8)), "");
          chk("R1", "upper bits", res >> 8, 32'h0);
          if (e == 7 && k >= 1 && k <= 7) begin
            sx = (x >= 128) ? x - 256 : x;
            q = sx / (1 << k);
            if (sx < 0 && q * (1 << k) != sx) q = q - 1;
            chk("R6", "floor div", res, 32'(q) & 32'hFF);
          end
        end
      end
    end

    // Halfword width, discarded count bits exercised
    for (int p = 0; p < 12; p++)
      for (int e = 0; e < 8; e++)
        for (int k = 0; k < 32; k++)
          for (int j = 0; j < 8; j++)
            run(2'd1, 3'(e), pat(p), 8'(k | (j << 5)), (j != 0) ? "R3" : "");

    // Word width, both size codes
    for (int p = 0; p < 12; p++)
      for (int e = 0; e < 8; e++)
        for (int k = 0; k < 32; k++) begin
          run(2'd2, 3'(e), pat(p), 8'(k), "");
          run(2'd3, 3'(e), pat(p), 8'(k), "R1");
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule